// File: doc/BRIEF.md
# Detector channel hit sequencer

This block is the digital control for one silicon-strip readout channel. Two comparators feed it: a fast timing comparator that watches the amplified preamplifier output, and an energy comparator that watches the amplified shaper output. When the energy comparator fires, the sequencer waits a programmable number of clock cycles so the shaper can reach its peak. It then issues a one-cycle sample strobe to the peak-hold stage. After that it drives three reset lines for the analogue chain. All three assert together and release in a fixed order: preamplifier first, shaper next, peak hold and channel logic last, after a programmable extension.

The timing comparator drives a trigger output that rises straight from the comparator, with no clock in the path. The trigger falls on a clock edge once a programmable length has elapsed. A timestamp-valid flag records that the timing comparator fired before the channel reset. A latched-hit flag is offered to the channel scan logic. That flag is set only when the validate input is high at the moment the sample is saved, and it holds until the scan logic returns a done pulse. The analogue chain, the multi-channel scan and the timestamp counter lie outside this block.

Top module: `hitseq_channel`

## Requirements
- R1: When idle, the sequencer recognises the energy comparator on the first rising clock edge at which it is high, the detection edge. A comparator pulse that is high only at that edge still starts a full sequence.
- R2: `sample_o` is high for exactly one clock cycle. That cycle begins D rising edges after the detection edge, where D is `samp_dly_i`, raised to a minimum of 2.
- R3: `hit_o` is set at the edge that ends the sample cycle only if `valid_i` is high at that edge. The sample and reset sequence runs the same way whether `valid_i` is high or low.
- R4: `pre_rst_o`, `sha_rst_o` and `ph_rst_o` all go high together at the edge that ends the sample cycle.
- R5: `pre_rst_o` stays high for 2 cycles and `sha_rst_o` for 3 cycles.
- R6: `ph_rst_o` stays high for 4 + `rst_ext_i` cycles. The sequencer returns to idle when it falls.
- R7: `trig_o` rises combinationally when `tmg_cmp_i` rises while the trigger is armed. It falls at rising edge E0 + L, where E0 is the first rising edge that sees the comparator high and L is `trig_len_i`, with 0 treated as 1.
- R8: After a trigger pulse, `trig_o` stays low while `tmg_cmp_i` stays high. The trigger re-arms only once the pulse has ended and the comparator has been low at a clock edge.
- R9: `hit_o` holds until a clock edge at which `rd_done_i` is high, and it clears at that edge. If a new valid save happens at the same edge, the set wins.
- R10: `ts_valid_o` is set at any rising edge where `tmg_cmp_i` is high outside the reset sequence. It clears at the edge where the resets assert.
- R11: While `ph_rst_o` is high, the energy comparator starts no new sequence, and the timing comparator does not set `ts_valid_o`.
- R12: After `rst_ni` is released, all outputs are low and the trigger is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmg_cmp_i | input | 1 | Timing comparator output |
| nrg_cmp_i | input | 1 | Energy comparator output |
| valid_i | input | 1 | Validate level, sampled when data is saved |
| samp_dly_i | input | 4 | Detection-to-sample delay in cycles, minimum 2 |
| rst_ext_i | input | 4 | Extra cycles of peak-hold and logic reset |
| trig_len_i | input | 4 | Trigger length in cycles, 0 treated as 1 |
| rd_done_i | input | 1 | Readout-done pulse from the scan logic |
| sample_o | output | 1 | Peak-hold sample strobe |
| pre_rst_o | output | 1 | Preamplifier reset |
| sha_rst_o | output | 1 | Shaper reset |
| ph_rst_o | output | 1 | Peak-hold and channel-logic reset |
| trig_o | output | 1 | Trigger pulse |
| hit_o | output | 1 | Latched hit awaiting readout |
| ts_valid_o | output | 1 | Timing comparator latched since the last reset |

## Verification
The assertions check the ordering relations on every cycle. The strobe is always followed by all three resets together. The preamplifier reset always drops before the shaper reset, and the peak-hold reset drops last. The hit flag never rises apart from the reset assertion, it holds without a done pulse, and the timestamp flag is clear when the resets rise. The absolute cycle counts need the bench's directed scenarios: the sample delay and its floor of two, the reset extension and the trigger length. So do validate gating, re-arming of the trigger and comparator activity ignored during reset.

// File: rtl/hitseq_pkg.sv
package hitseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_SAMP = 2'd2,
        SEQ_RST  = 2'd3
    } seq_state_e;

    localparam int unsigned PRE_HOLD_CYC = 2;
    localparam int unsigned SHA_HOLD_CYC = 3;
    localparam int unsigned PH_BASE_CYC  = 4;
    localparam int unsigned MIN_SAMP_DLY = 2;

endpackage

// File: rtl/hitseq_trig.sv
module hitseq_trig #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tmg_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             trig_o
);

    typedef struct packed {
        logic             armed;
        logic [LEN_W-1:0] cnt;
    } trig_t;

    trig_t            trg_d, trg_q;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
        trg_d   = trg_q;
        if (trg_q.armed && tmg_i) begin
            trg_d.armed = 1'b0;
            trg_d.cnt   = len_eff;
        end else begin
            if (trg_q.cnt != '0) begin
                trg_d.cnt = trg_q.cnt - LEN_W'(1);
            end
            if (!trg_q.armed && (trg_q.cnt == '0) && !tmg_i) begin
                trg_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trg_q <= '{armed: 1'b1, cnt: '0};
        end else begin
            trg_q <= trg_d;
        end
    end

    // rising edge passes straight from the comparator; falling edge comes from the counter
    assign trig_o = (trg_q.armed & tmg_i) | (trg_q.cnt != '0);

endmodule

// File: rtl/hitseq_fsm.sv
module hitseq_fsm
    import hitseq_pkg::*;
#(
    parameter int unsigned DLY_W = 4,
    parameter int unsigned EXT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             nrg_i,
    input  logic [DLY_W-1:0] samp_dly_i,
    input  logic [EXT_W-1:0] rst_ext_i,
    output logic             sample_o,
    output logic             in_rst_o,
    output logic             pre_rst_o,
    output logic             sha_rst_o,
    output logic             ph_rst_o
);

    localparam int unsigned CNT_W = ((DLY_W > EXT_W) ? DLY_W : EXT_W) + 2;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] dly_eff;
    logic [CNT_W-1:0] ph_len;

    always_comb begin
        dly_eff = (CNT_W'(samp_dly_i) < CNT_W'(MIN_SAMP_DLY))
                ? CNT_W'(MIN_SAMP_DLY) : CNT_W'(samp_dly_i);
        ph_len  = CNT_W'(PH_BASE_CYC) + CNT_W'(rst_ext_i);
        seq_d   = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (nrg_i) begin
                    seq_d.st  = SEQ_WAIT;
                    seq_d.cnt = dly_eff;
                end
            end
            SEQ_WAIT: begin
                if (seq_q.cnt == CNT_W'(1)) begin
                    seq_d.st  = SEQ_SAMP;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_SAMP: begin
                seq_d.st  = SEQ_RST;
                seq_d.cnt = '0;
            end
            SEQ_RST: begin
                if (seq_q.cnt == ph_len - CNT_W'(1)) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d = '{st: SEQ_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sample_o  = (seq_q.st == SEQ_SAMP);
    assign in_rst_o  = (seq_q.st == SEQ_RST);
    assign pre_rst_o = in_rst_o && (seq_q.cnt < CNT_W'(PRE_HOLD_CYC));
    assign sha_rst_o = in_rst_o && (seq_q.cnt < CNT_W'(SHA_HOLD_CYC));
    assign ph_rst_o  = in_rst_o;

endmodule

// File: rtl/hitseq_flags.sv
module hitseq_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tmg_i,
    input  logic valid_i,
    input  logic save_i,
    input  logic in_rst_i,
    input  logic rd_done_i,
    output logic hit_o,
    output logic ts_valid_o
);

    typedef struct packed {
        logic hit;
        logic ts;
    } flag_t;

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d.hit = (save_i & valid_i) | (flg_q.hit & ~rd_done_i);
        if (save_i || in_rst_i) begin
            flg_d.ts = 1'b0;
        end else begin
            flg_d.ts = flg_q.ts | tmg_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign hit_o      = flg_q.hit;
    assign ts_valid_o = flg_q.ts;

endmodule

// File: rtl/hitseq_channel.sv
module hitseq_channel #(
    parameter int unsigned DLY_W = 4,
    parameter int unsigned EXT_W = 4,
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tmg_cmp_i,
    input  logic             nrg_cmp_i,
    input  logic             valid_i,
    input  logic [DLY_W-1:0] samp_dly_i,
    input  logic [EXT_W-1:0] rst_ext_i,
    input  logic [LEN_W-1:0] trig_len_i,
    input  logic             rd_done_i,
    output logic             sample_o,
    output logic             pre_rst_o,
    output logic             sha_rst_o,
    output logic             ph_rst_o,
    output logic             trig_o,
    output logic             hit_o,
    output logic             ts_valid_o
);

    logic sample_w;
    logic in_rst_w;

    hitseq_fsm #(
        .DLY_W (DLY_W),
        .EXT_W (EXT_W)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .nrg_i      (nrg_cmp_i),
        .samp_dly_i (samp_dly_i),
        .rst_ext_i  (rst_ext_i),
        .sample_o   (sample_w),
        .in_rst_o   (in_rst_w),
        .pre_rst_o  (pre_rst_o),
        .sha_rst_o  (sha_rst_o),
        .ph_rst_o   (ph_rst_o)
    );

    hitseq_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tmg_i      (tmg_cmp_i),
        .valid_i    (valid_i),
        .save_i     (sample_w),
        .in_rst_i   (in_rst_w),
        .rd_done_i  (rd_done_i),
        .hit_o      (hit_o),
        .ts_valid_o (ts_valid_o)
    );

    hitseq_trig #(
        .LEN_W (LEN_W)
    ) u_trig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tmg_i  (tmg_cmp_i),
        .len_i  (trig_len_i),
        .trig_o (trig_o)
    );

    assign sample_o = sample_w;

endmodule

// File: rtl/hitseq_channel_chk.sv
module hitseq_channel_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic rd_done_i,
    input logic sample_o,
    input logic pre_rst_o,
    input logic sha_rst_o,
    input logic ph_rst_o,
    input logic hit_o,
    input logic ts_valid_o
);

    AST_SAMPLE_THEN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> (!sample_o && pre_rst_o)); // R2

    AST_RST_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pre_rst_o) |-> ($rose(sha_rst_o) && $rose(ph_rst_o))); // R4

    AST_PRE_BEFORE_SHA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sha_rst_o) |-> (!pre_rst_o && !$past(pre_rst_o))); // R5

    AST_PH_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ph_rst_o) |-> (!sha_rst_o && !pre_rst_o)); // R6

    AST_NO_SAMPLE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ph_rst_o |-> !sample_o); // R11

    AST_HIT_AT_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hit_o) |-> $rose(pre_rst_o)); // R3

    AST_HIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_o && !rd_done_i) |=> hit_o); // R9

    AST_TS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pre_rst_o) |-> !ts_valid_o); // R10

endmodule

bind hitseq_channel hitseq_channel_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_done_i  (rd_done_i),
    .sample_o   (sample_o),
    .pre_rst_o  (pre_rst_o),
    .sha_rst_o  (sha_rst_o),
    .ph_rst_o   (ph_rst_o),
    .hit_o      (hit_o),
    .ts_valid_o (ts_valid_o)
);

// File: tb/hitseq_channel_bench.sv
module hitseq_channel_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmg = 1'b0;
    logic       nrg = 1'b0;
    logic       valid = 1'b0;
    logic [3:0] samp_dly = 4'd2;
    logic [3:0] rst_ext = 4'd0;
    logic [3:0] trig_len = 4'd1;
    logic       rd_done = 1'b0;
    logic       sample_o, pre_rst_o, sha_rst_o, ph_rst_o, trig_o, hit_o, ts_valid_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hitseq_channel u_hitseq_channel (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tmg_cmp_i  (tmg),
        .nrg_cmp_i  (nrg),
        .valid_i    (valid),
        .samp_dly_i (samp_dly),
        .rst_ext_i  (rst_ext),
        .trig_len_i (trig_len),
        .rd_done_i  (rd_done),
        .sample_o   (sample_o),
        .pre_rst_o  (pre_rst_o),
        .sha_rst_o  (sha_rst_o),
        .ph_rst_o   (ph_rst_o),
        .trig_o     (trig_o),
        .hit_o      (hit_o),
        .ts_valid_o (ts_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({sample_o, pre_rst_o, sha_rst_o, ph_rst_o, trig_o, hit_o, ts_valid_o} == 7'd0,
            "R12", {sample_o, pre_rst_o, sha_rst_o, ph_rst_o, trig_o, hit_o, ts_valid_o}, 0);
    endtask

    task automatic t_done();
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
        chk(hit_o == 1'b0, "R9", hit_o, 0);
    endtask

    task automatic t_hit(input int sd, input int xr, input bit val, input bit done_at_save);
        int de;
        bit hb;
        bit eh;
        de = (sd < 2) ? 2 : sd;
        @(negedge clk);
        samp_dly = 4'(sd); rst_ext = 4'(xr); valid = val; hb = hit_o; nrg = 1'b1;
        for (int k = 1; k <= de + 8 + xr; k++) begin
            @(negedge clk);
            if (k == 1) nrg = 1'b0;
            if (k == de + 1) chk(sample_o == 1'b1, "R1", sample_o, 1);
            chk(sample_o == (k == de + 1), "R2", sample_o, int'(k == de + 1));
            if (k == de + 2) chk(pre_rst_o && sha_rst_o && ph_rst_o, "R4",
                                 {pre_rst_o, sha_rst_o, ph_rst_o}, 7);
            chk(pre_rst_o == (k >= de + 2 && k <= de + 3), "R5", pre_rst_o,
                int'(k >= de + 2 && k <= de + 3));
            chk(sha_rst_o == (k >= de + 2 && k <= de + 4), "R5", sha_rst_o,
                int'(k >= de + 2 && k <= de + 4));
            chk(ph_rst_o == (k >= de + 2 && k <= de + 5 + xr), "R6", ph_rst_o,
                int'(k >= de + 2 && k <= de + 5 + xr));
            eh = (k < de + 2) ? hb : (val | (hb & ~done_at_save));
            chk(hit_o == eh, done_at_save ? "R9" : "R3", hit_o, eh);
            if (k >= de + 2) chk(ts_valid_o == 1'b0, "R10", ts_valid_o, 0);
            if (k == de + 1 && done_at_save) rd_done = 1'b1;
            if (k == de + 2) rd_done = 1'b0;
        end
        if (hit_o) t_done();
    endtask

    task automatic t_trig(input int len, input int hold);
        int lm;
        int last;
        lm = (len == 0) ? 1 : len;
        last = ((lm > hold) ? lm : hold) + 3;
        @(negedge clk);
        trig_len = 4'(len); tmg = 1'b1;
        #1 chk(trig_o == 1'b1, "R7", trig_o, 1);
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            chk(trig_o == (k <= lm), (k > lm && k <= hold) ? "R8" : "R7", trig_o, int'(k <= lm));
            if (k == 1) chk(ts_valid_o == 1'b1, "R10", ts_valid_o, 1);
            if (k == hold) tmg = 1'b0;
        end
        @(negedge clk); tmg = 1'b1;
        #1 chk(trig_o == 1'b1, "R8", trig_o, 1);
        @(negedge clk); tmg = 1'b0;
        repeat (lm + 3) @(negedge clk);
    endtask

    task automatic t_ignore();
        int de;
        de = 2;
        @(negedge clk);
        samp_dly = 4'd2; rst_ext = 4'd4; valid = 1'b0; nrg = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k == 1) nrg = 1'b0;
            if (k == de + 3) begin nrg = 1'b1; tmg = 1'b1; end
            if (k == de + 4) begin nrg = 1'b0; tmg = 1'b0; end
            if (k >= de + 4 && k <= de + 5 + 4) chk(ts_valid_o == 1'b0, "R11", ts_valid_o, 0);
            if (k > de + 1) chk(sample_o == 1'b0, "R11", sample_o, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_trig(3, 1);
        t_hit(5, 1, 1'b1, 1'b0);
        t_hit(0, 0, 1'b0, 1'b0);
        t_trig(1, 1);
        t_trig(4, 8);
        t_trig(0, 2);
        t_hit(1, 2, 1'b1, 1'b1);
        t_hit(15, 15, 1'b1, 1'b0);
        t_ignore();
        t_hit(3, 0, 1'b1, 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule